// File: doc/BRIEF.md
# SDRAM Command and Refresh Sequencer

This block sits between a simple single-request interface and a four-bank synchronous DRAM. It drives the clock enable, the four command strobes, the bank select and the multiplexed address pins. After reset it holds the clock enable low for a programmable wait. It then runs a fixed bring-up sequence: precharge all banks, two auto-refresh commands, and a load of the mode register. After that it serves one request at a time with a closed-page policy. It opens the row, issues the read or write column command with or without auto-precharge, and closes the bank itself when auto-precharge was not asked for.

Every minimum spacing between commands is counted in clocks. The nanosecond limits are divided by a clock-period parameter and rounded up. A separate counter raises a refresh request at a fixed rate of one row per 64 ms / 4096. A pending refresh is served at the next idle point ahead of any waiting request, and never while a row is open. A requester raises `reqValid` with bank, row, column, direction and auto-precharge flag, and holds them until `reqReady` is high in a cycle. That cycle is the acceptance.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted and for INIT_CYCLES clock edges after its release, sdCke is low, the command is NOP, and initDone and reqReady are low.
- R2: Bring-up issues, in this order, precharge with A10 high, auto-refresh, auto-refresh, mode register set. The spacings are at least nRP after the precharge and at least nRRC after each refresh. No bank is activated before the mode register set.
- R3: The mode register set drives A2..A0 = log2(BURST_LEN), A3 = 0 (sequential), A6..A4 = CAS_LAT, and all other address bits 0. initDone is high from the cycle that command appears. No command follows it for 2 cycles.
- R4: Commands on {sdCsN, sdRasN, sdCasN, sdWeN} are encoded as: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. No other code is driven.
- R5: A request is accepted in a cycle with reqReady high. In the next cycle an activate appears, with sdBa equal to the bank and sdAddr equal to the row.
- R6: The column command follows its activate by at least nRCD cycles. It carries the same bank, the column on A8..A0, the auto-precharge flag on A10, and zero on A9 and A11. It is a write exactly when the request was a write.
- R7: Without auto-precharge, a precharge of that bank alone (A10 low) follows the column command by at least BURST_LEN cycles. This covers one clock after the last write data.
- R8: Successive activates are at least nRC cycles apart, and an activate follows any precharge by at least nRP cycles.
- R9: After a column command with auto-precharge, the next activate or refresh waits at least BURST_LEN-1+4 cycles after a write and at least BURST_LEN+nRP cycles after a read.
- R10: After bring-up, a refresh becomes due every floor(REF_PERIOD_NS/CLK_NS) cycles. It is issued only with no row open, ahead of any waiting request, and is followed by at least nRRC idle cycles.
- R11: nRCD, nRP, nRC and nRRC are the ns limits divided by CLK_NS and rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAutoPre | input | 1 | Close the row with auto-precharge |
| reqBank | input | BANK_BITS | Bank of the request |
| reqRow | input | ROW_BITS | Row of the request |
| reqCol | input | COL_BITS | Column of the request |
| reqReady | output | 1 | Request accepted this cycle |
| initDone | output | 1 | Bring-up finished |
| sdCke | output | 1 | DRAM clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_BITS | Bank select |
| sdAddr | output | ROW_BITS | Multiplexed address |

## Verification
The bench runs a clock-period setting that forces every nanosecond limit to round up. It then sweeps all four banks against every combination of direction and auto-precharge, first back to back and then with gaps, while refreshes keep falling due under load. A monitor timestamps every command and measures each gap against bounds worked out in the bench. A design that truncated instead of rounding up, or that reused the precharge gap after auto-precharge writes, would place some command a cycle early. A design that let traffic starve refresh, or refreshed with a row open, would break the refresh interval window or the open-row check. Wrong bits on A10, A9 or in the mode word show up as field mismatches.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    A_NONE, A_ROW, A_COL, A_MODE, A_ALL, A_BANK
  } addr_e;

  typedef enum logic [3:0] {
    W_NONE, W_RCD, W_RP, W_RRC, W_MRD, W_COLPRE, W_POSTPRE, W_AUTOWR, W_AUTORD
  } wait_e;

  typedef struct packed {
    cmd_e  cmd;
    addr_e addrSel;
    wait_e waitSel;
    logic  take;
    logic  refClr;
    logic  ckeOn;
    logic  refRun;
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    timerZero,
  input  logic    refPending,
  input  logic    curWrite,
  input  logic    curAuto,
  output strobe_t strb,
  output logic    reqReady,
  output logic    initDone
);

  typedef enum logic [2:0] {
    S_PWR, S_IPRE, S_IREF1, S_IREF2, S_MRS, S_IDLE, S_COL, S_PRE
  } state_e;

  state_e state, nState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_PWR;
    else       state <= nState;
  end

  assign initDone = (state == S_IDLE) || (state == S_COL) || (state == S_PRE);

  always_comb begin
    nState       = state;
    reqReady     = 1'b0;
    strb.cmd     = CMD_NOP;
    strb.addrSel = A_NONE;
    strb.waitSel = W_NONE;
    strb.take    = 1'b0;
    strb.refClr  = 1'b0;
    strb.ckeOn   = (state != S_PWR) || timerZero;
    strb.refRun  = initDone;
    if (timerZero) begin
      unique case (state)
        S_PWR: nState = S_IPRE;
        S_IPRE: begin
          strb.cmd = CMD_PRE; strb.addrSel = A_ALL; strb.waitSel = W_RP;
          nState = S_IREF1;
        end
        S_IREF1: begin
          strb.cmd = CMD_REF; strb.waitSel = W_RRC;
          nState = S_IREF2;
        end
        S_IREF2: begin
          strb.cmd = CMD_REF; strb.waitSel = W_RRC;
          nState = S_MRS;
        end
        S_MRS: begin
          strb.cmd = CMD_MRS; strb.addrSel = A_MODE; strb.waitSel = W_MRD;
          nState = S_IDLE;
        end
        S_IDLE: begin
          if (refPending) begin
            strb.cmd = CMD_REF; strb.waitSel = W_RRC; strb.refClr = 1'b1;
          end else if (reqValid) begin
            strb.cmd = CMD_ACT; strb.addrSel = A_ROW; strb.waitSel = W_RCD;
            strb.take = 1'b1; reqReady = 1'b1;
            nState = S_COL;
          end
        end
        S_COL: begin
          strb.cmd     = curWrite ? CMD_WR : CMD_RD;
          strb.addrSel = A_COL;
          if (curAuto) begin
            strb.waitSel = curWrite ? W_AUTOWR : W_AUTORD;
            nState = S_IDLE;
          end else begin
            strb.waitSel = W_COLPRE;
            nState = S_PRE;
          end
        end
        S_PRE: begin
          strb.cmd = CMD_PRE; strb.addrSel = A_BANK; strb.waitSel = W_POSTPRE;
          nState = S_IDLE;
        end
        default: nState = S_PWR;
      endcase
    end
  end

  // R10
  ref_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !refPending);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> (state == S_COL));

endmodule

// File: rtl/sdram_seq_dp.sv
`timescale 1ns/1ps
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int INIT_CYCLES   = 20000,
  parameter int BURST_LEN     = 1,
  parameter int CAS_LAT       = 2,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_RRC_NS      = 70,
  parameter int REF_PERIOD_NS = 15625,
  parameter int ROW_BITS      = 12,
  parameter int COL_BITS      = 9,
  parameter int BANK_BITS     = 2
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 reqWrite,
  input  logic                 reqAutoPre,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  output logic                 timerZero,
  output logic                 refPending,
  output logic                 curWrite,
  output logic                 curAuto,
  output logic                 sdCke,
  output cmd_e                 cmdOut,
  output logic [BANK_BITS-1:0] sdBa,
  output logic [ROW_BITS-1:0]  sdAddr
);

  localparam int N_RCD     = imax(cdiv(T_RCD_NS, CLK_NS), 1);
  localparam int N_RP      = imax(cdiv(T_RP_NS, CLK_NS), 1);
  localparam int N_RC      = imax(cdiv(T_RC_NS, CLK_NS), 1);
  localparam int N_RRC     = imax(cdiv(T_RRC_NS, CLK_NS), 1);
  localparam int N_MRD     = 2;
  localparam int N_DPL     = 1;
  localparam int N_DAL     = 4;
  localparam int N_COLPRE  = imax(BURST_LEN, BURST_LEN - 1 + N_DPL);
  localparam int N_POSTPRE = imax(N_RP, N_RC - N_RCD - N_COLPRE);
  localparam int N_AUTOWR  = imax(BURST_LEN - 1 + N_DAL, N_RC - N_RCD);
  localparam int N_AUTORD  = imax(BURST_LEN + N_RP, N_RC - N_RCD);
  localparam int REF_INT   = imax(REF_PERIOD_NS / CLK_NS, 2);
  localparam int TW        = $clog2(imax(INIT_CYCLES, 64) + 1) + 1;
  localparam int RW        = $clog2(REF_INT + 1);
  localparam int BL_CODE   = $clog2(BURST_LEN);
  localparam int MODE_INT  = (CAS_LAT % 8) * 16 + (BL_CODE % 8);
  localparam logic [ROW_BITS-1:0] MODE_WORD = ROW_BITS'(MODE_INT);
  localparam int AP_BIT    = 10;

  logic [TW-1:0]        waitCnt, loadVal;
  logic [RW-1:0]        refCnt;
  logic [BANK_BITS-1:0] curBank, nxtBa;
  logic [COL_BITS-1:0]  curCol;
  logic [ROW_BITS-1:0]  nxtAddr;
  logic                 ckeQ;

  assign timerZero = (waitCnt == '0);
  assign sdCke     = ckeQ;

  always_comb begin
    unique case (strb.waitSel)
      W_RCD:     loadVal = TW'(N_RCD - 1);
      W_RP:      loadVal = TW'(N_RP - 1);
      W_RRC:     loadVal = TW'(N_RRC - 1);
      W_MRD:     loadVal = TW'(N_MRD - 1);
      W_COLPRE:  loadVal = TW'(N_COLPRE - 1);
      W_POSTPRE: loadVal = TW'(N_POSTPRE - 1);
      W_AUTOWR:  loadVal = TW'(N_AUTOWR - 1);
      W_AUTORD:  loadVal = TW'(N_AUTORD - 1);
      default:   loadVal = '0;
    endcase
  end

  always_comb begin
    nxtAddr = '0;
    nxtBa   = '0;
    unique case (strb.addrSel)
      A_ROW: begin
        nxtAddr = reqRow;
        nxtBa   = reqBank;
      end
      A_COL: begin
        nxtAddr[COL_BITS-1:0] = curCol;
        nxtAddr[AP_BIT]       = curAuto;
        nxtBa                 = curBank;
      end
      A_MODE: nxtAddr = MODE_WORD;
      A_ALL:  nxtAddr[AP_BIT] = 1'b1;
      A_BANK: nxtBa = curBank;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= TW'(INIT_CYCLES);
      cmdOut  <= CMD_NOP;
      sdAddr  <= '0;
      sdBa    <= '0;
      ckeQ    <= 1'b0;
    end else begin
      if (strb.cmd != CMD_NOP) waitCnt <= loadVal;
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
      cmdOut <= strb.cmd;
      sdAddr <= nxtAddr;
      sdBa   <= nxtBa;
      ckeQ   <= strb.ckeOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBank  <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curAuto  <= 1'b0;
    end else if (strb.take) begin
      curBank  <= reqBank;
      curCol   <= reqCol;
      curWrite <= reqWrite;
      curAuto  <= reqAutoPre;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (strb.refClr) refPending <= 1'b0;
      if (!strb.refRun) begin
        refCnt <= '0;
      end else if (refCnt == RW'(REF_INT - 1)) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  // R8
  spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmd != CMD_NOP) |-> (waitCnt == '0));

  // R10
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && !strb.refClr) |=> refPending);

  // R1
  cke_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ckeQ |-> (cmdOut == CMD_NOP));

  // R2
  take_after_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> strb.refRun);

endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int INIT_CYCLES   = 20000,
  parameter int BURST_LEN     = 1,
  parameter int CAS_LAT       = 2,
  parameter int T_RCD_NS      = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_RRC_NS      = 70,
  parameter int REF_PERIOD_NS = 15625,
  parameter int ROW_BITS      = 12,
  parameter int COL_BITS      = 9,
  parameter int BANK_BITS     = 2
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqAutoPre,
  input  logic [BANK_BITS-1:0] reqBank,
  input  logic [ROW_BITS-1:0]  reqRow,
  input  logic [COL_BITS-1:0]  reqCol,
  output logic                 reqReady,
  output logic                 initDone,
  output logic                 sdCke,
  output logic                 sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_BITS-1:0] sdBa,
  output logic [ROW_BITS-1:0]  sdAddr
);

  strobe_t strb;
  cmd_e    cmdOut;
  logic    timerZero, refPending, curWrite, curAuto;

  sdram_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .timerZero(timerZero),
    .refPending(refPending), .curWrite(curWrite), .curAuto(curAuto),
    .strb(strb), .reqReady(reqReady), .initDone(initDone)
  );

  sdram_seq_dp #(
    .CLK_NS(CLK_NS), .INIT_CYCLES(INIT_CYCLES), .BURST_LEN(BURST_LEN),
    .CAS_LAT(CAS_LAT), .T_RCD_NS(T_RCD_NS), .T_RP_NS(T_RP_NS),
    .T_RC_NS(T_RC_NS), .T_RRC_NS(T_RRC_NS), .REF_PERIOD_NS(REF_PERIOD_NS),
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .BANK_BITS(BANK_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqAutoPre(reqAutoPre), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .timerZero(timerZero), .refPending(refPending), .curWrite(curWrite),
    .curAuto(curAuto), .sdCke(sdCke), .cmdOut(cmdOut), .sdBa(sdBa), .sdAddr(sdAddr)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdOut;

endmodule

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_CLK_NS = 8;
  localparam int P_INIT   = 50;
  localparam int P_BL     = 2;
  localparam int P_CL     = 2;
  localparam int P_REF_NS = 1600;
  localparam int E_RCD  = (20 + P_CLK_NS - 1) / P_CLK_NS;
  localparam int E_RP   = (20 + P_CLK_NS - 1) / P_CLK_NS;
  localparam int E_RC   = (70 + P_CLK_NS - 1) / P_CLK_NS;
  localparam int E_RRC  = (70 + P_CLK_NS - 1) / P_CLK_NS;
  localparam int E_INT  = P_REF_NS / P_CLK_NS;
  localparam int E_MODE = P_CL * 16 + 1;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqAutoPre = 1'b0;
  logic [1:0] reqBank = '0;
  logic [11:0] reqRow = '0;
  logic [8:0] reqCol = '0;
  logic reqReady, initDone, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0] sdBa;
  logic [11:0] sdAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_seq #(
    .CLK_NS(P_CLK_NS), .INIT_CYCLES(P_INIT), .BURST_LEN(P_BL), .CAS_LAT(P_CL),
    .REF_PERIOD_NS(P_REF_NS)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAutoPre(reqAutoPre), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqReady(reqReady), .initDone(initDone), .sdCke(sdCke), .sdCsN(sdCsN),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr)
  );

  int nChk = 0, nFail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  int accBank, accRow, accCol, accWr, accAuto;
  int curBank, curRow, curCol, curWr, curAuto;
  int lastAct = -1000, lastCol = -1000, lastPre = -1000, lastRef = -1000, lastMrs = -1000;
  int refBase = -1, nAct = 0, nCol = 0, nRef = 0, initStep = 0;
  bit rowOpen = 0, colWr = 0, colAuto = 0, mrsSeen = 0;
  logic [3:0] cmdNow;

  always @(negedge clk) begin
    if (rstN) begin
      cmdNow = {sdCsN, sdRasN, sdCasN, sdWeN};
      if (cyc == P_INIT) begin
        chk(sdCke == 1'b0, "R1 cke low through wait", sdCke, 0);
        chk(cmdNow == C_NOP, "R1 nop through wait", cmdNow, C_NOP);
      end
      if (cmdNow != C_NOP) begin
        if (mrsSeen) chk(cyc - lastMrs >= 2, "R3 gap after mode set", cyc - lastMrs, 2);
        chk(cyc - lastRef >= E_RRC, "R10 gap after refresh", cyc - lastRef, E_RRC);
        chk(sdCke == 1'b1, "R1 cke high for commands", sdCke, 1);
        case (cmdNow)
          C_PRE: begin
            if (initStep == 0) begin
              chk(sdAddr[10] == 1'b1, "R2 first precharge is all-bank", sdAddr[10], 1);
              initStep = 1;
            end else begin
              chk(rowOpen, "R7 precharge with open row", rowOpen, 1);
              chk(sdAddr[10] == 1'b0, "R7 single-bank precharge", sdAddr[10], 0);
              chk(sdBa == curBank, "R7 precharge bank", sdBa, curBank);
              chk(cyc - lastCol >= (colWr ? P_BL - 1 + 1 : P_BL), "R7 column to precharge",
                  cyc - lastCol, P_BL);
              rowOpen = 0;
            end
            lastPre = cyc;
          end
          C_REF: begin
            chk(!rowOpen, "R10 refresh with no open row", rowOpen, 0);
            chk(cyc - lastPre >= E_RP, "R11 precharge to refresh", cyc - lastPre, E_RP);
            if (initStep == 1 || initStep == 2) begin
              initStep++;
            end else begin
              chk(initStep == 4, "R2 refresh order", initStep, 4);
              if (colAuto)
                chk(cyc - lastCol >= (colWr ? P_BL + 3 : P_BL + E_RP), "R9 auto-precharge to refresh",
                    cyc - lastCol, colWr ? P_BL + 3 : P_BL + E_RP);
              chk(cyc - refBase >= E_INT - 12 && cyc - refBase <= E_INT + 14,
                  "R10 refresh interval", cyc - refBase, E_INT);
              refBase = cyc;
              nRef++;
            end
            lastRef = cyc;
          end
          C_MRS: begin
            chk(initStep == 3, "R2 mode set after two refreshes", initStep, 3);
            chk(sdAddr == 12'(E_MODE), "R3 mode word", sdAddr, E_MODE);
            chk(initDone == 1'b1, "R3 initDone with mode set", initDone, 1);
            initStep = 4;
            mrsSeen = 1;
            lastMrs = cyc;
            refBase = cyc;
          end
          C_ACT: begin
            chk(initStep == 4, "R2 activate only after bring-up", initStep, 4);
            chk(!rowOpen, "R8 activate with bank closed", rowOpen, 0);
            chk(cyc - lastAct >= E_RC, "R8 activate to activate", cyc - lastAct, E_RC);
            chk(cyc - lastPre >= E_RP, "R8 precharge to activate", cyc - lastPre, E_RP);
            if (colAuto)
              chk(cyc - lastCol >= (colWr ? P_BL + 3 : P_BL + E_RP), "R9 auto-precharge to activate",
                  cyc - lastCol, colWr ? P_BL + 3 : P_BL + E_RP);
            chk(sdBa == accBank, "R5 activate bank", sdBa, accBank);
            chk(sdAddr == 12'(accRow), "R5 activate row", sdAddr, accRow);
            curBank = accBank; curRow = accRow; curCol = accCol; curWr = accWr; curAuto = accAuto;
            rowOpen = 1;
            lastAct = cyc;
            nAct++;
          end
          C_RD, C_WR: begin
            chk(rowOpen, "R6 column with open row", rowOpen, 1);
            chk(cyc - lastAct >= E_RCD, "R6 R11 activate to column", cyc - lastAct, E_RCD);
            chk(sdBa == curBank, "R6 column bank", sdBa, curBank);
            chk(sdAddr[8:0] == 9'(curCol), "R6 column address", sdAddr[8:0], curCol);
            chk(sdAddr[10] == curAuto[0], "R6 auto-precharge bit", sdAddr[10], curAuto);
            chk(sdAddr[11] == 1'b0 && sdAddr[9] == 1'b0, "R6 unused bits zero", sdAddr, 0);
            chk((cmdNow == C_WR) == (curWr != 0), "R4 read/write code", cmdNow, curWr ? C_WR : C_RD);
            colWr = (cmdNow == C_WR);
            colAuto = sdAddr[10];
            if (colAuto) rowOpen = 0;
            lastCol = cyc;
            nCol++;
          end
          default: chk(1'b0, "R4 illegal command code", cmdNow, C_NOP);
        endcase
      end
    end
  end

  task automatic send(input int b, input int w, input int a, input int row, input int col);
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'(b); reqWrite = w[0]; reqAutoPre = a[0];
    reqRow = 12'(row); reqCol = 9'(col);
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    accBank = b; accRow = row; accCol = col; accWr = w; accAuto = a;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdCke == 1'b0, "R1 reset cke", sdCke, 0);
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1 reset command", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
    chk(initDone == 1'b0, "R1 reset initDone", initDone, 0);
    chk(reqReady == 1'b0, "R1 reset reqReady", reqReady, 0);
    rstN = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i >= 16) repeat (i % 5) @(negedge clk);
      send(i % 4, (i / 4) % 2, (i / 8) % 2, (i * 397 + 5) % 4096, (i * 53 + 7) % 512);
    end
    repeat (3 * E_INT) @(negedge clk);
    chk(nAct == 32, "R5 every request activated", nAct, 32);
    chk(nCol == 32, "R6 every request got a column command", nCol, 32);
    chk(initStep == 4, "R2 bring-up completed", initStep, 4);
    chk(nRef >= (cyc - lastMrs) / E_INT - 1, "R10 refresh count", nRef, (cyc - lastMrs) / E_INT - 1);
    finishRun();
  end

endmodule